// File: doc/BRIEF.md
# Self-Starting Five-State Counter

This block is a 3-bit synchronous counter that walks a fixed, non-binary cycle of five codes instead of counting in binary. Each state bit sits in its own toggle-type register, and a small decoder works out, for every bit, whether it must flip on the next edge. The outputs are the three state bits, most significant first.

The three codes that the cycle never visits are given explicit successors rather than being left free for logic minimisation. Whatever code the register holds after power-up or an upset, one enabled clock edge brings it back onto the cycle, so the counter can never be trapped among unused codes.

A synchronous active-high reset clears the state. A test-only load path lets a bench place any code, including the unused ones, into the register to prove recovery.

Top module: `self_start_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 000 on that edge, whatever `en`, `tst_ld` and `tst_code` are.
- R2: With `en` high, `rst` low and `tst_ld` low, each rising edge advances the state (C,B,A) along 000 → 010 → 011 → 101 → 110 and from 110 back to 000.
- R3: With `en` high, `rst` low and `tst_ld` low, a state of 001, 100 or 111 becomes 000 on the next rising edge.
- R4: With `en` low, `rst` low and `tst_ld` low, the state keeps its value across the edge, including when it holds an unused code.
- R5: With `rst` low and `tst_ld` high, the state takes the value of `tst_code` (bit 2 to C, bit 1 to B, bit 0 to A) on the next edge, whatever `en` is.
- R6: The output `cnt_c` carries the most significant state bit, `cnt_b` the middle one and `cnt_a` the least significant one.
- R7: Two consecutive enabled edges without reset or load never both leave the state on an unused code.
- R8: Each state bit changes across an edge only when its toggle input, present bit XOR next bit, is one; otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 000 |
| en | input | 1 | Advance the count on this edge |
| tst_ld | input | 1 | Test-only: load `tst_code` on this edge |
| tst_code | input | 3 | Test-only code to load, bit 2 = C |
| cnt_c | output | 1 | State bit C (most significant) |
| cnt_b | output | 1 | State bit B |
| cnt_a | output | 1 | State bit A (least significant) |

## Verification
All eight codes are loaded one by one and followed by a single enabled edge, which separates a correct successor table from one that treats 001, 100 or 111 as don't-cares or sends them into another unused code. The same eight loads followed by a disabled edge tell a true hold apart from toggle inputs that leak while `en` is low. Free running from reset over several wraps checks the cycle order against a table kept in the bench, and simultaneous reset, load and enable patterns pin down the priority between the three controls.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int unsigned ST_W    = 3;
    localparam int unsigned CYC_LEN = 5;

    typedef logic [ST_W-1:0] code_t;

    typedef struct packed {
        logic c;
        logic b;
        logic a;
    } state_t;

    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_STEP  = 2'd2,
        ACT_HOLD  = 2'd3
    } act_e;

    // Successor of any code; unused codes are steered back to zero.
    function automatic code_t succ(input code_t cur);
        code_t n;
        unique case (cur)
            3'b000:  n = 3'b010;
            3'b010:  n = 3'b011;
            3'b011:  n = 3'b101;
            3'b101:  n = 3'b110;
            3'b110:  n = 3'b000;
            default: n = 3'b000;
        endcase
        return n;
    endfunction

    function automatic logic is_unused(input code_t cur);
        return (cur == 3'b001) || (cur == 3'b100) || (cur == 3'b111);
    endfunction

    function automatic code_t to_code(input state_t s);
        return {s.c, s.b, s.a};
    endfunction

endpackage

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
    import ssc_pkg::*;
(
    input  logic rst,
    input  logic en,
    input  logic ld,
    output act_e act
);
    always_comb begin
        if (rst)      act = ACT_CLEAR;
        else if (ld)  act = ACT_LOAD;
        else if (en)  act = ACT_STEP;
        else          act = ACT_HOLD;
    end
endmodule

// File: rtl/ssc_next.sv
module ssc_next
    import ssc_pkg::*;
(
    input  act_e  act,
    input  code_t cur,
    output code_t tog
);
    code_t nxt;

    always_comb begin
        nxt = succ(cur);
        if (act == ACT_STEP) tog = cur ^ nxt;
        else                 tog = '0;
    end
endmodule

// File: rtl/ssc_tbit.sv
module ssc_tbit
    import ssc_pkg::*;
(
    input  logic clk,
    input  act_e act,
    input  logic t,
    input  logic ld_val,
    output logic q
);
    always_ff @(posedge clk) begin
        unique case (act)
            ACT_CLEAR: q <= 1'b0;
            ACT_LOAD:  q <= ld_val;
            ACT_STEP:  q <= q ^ t;
            default:   q <= q;
        endcase
    end

    // R8
    t_zero_hold_chk: assert property (@(posedge clk)
        disable iff (act == ACT_CLEAR || act == ACT_LOAD)
        (act == ACT_HOLD || !t) |=> $stable(q));
endmodule

// File: rtl/self_start_counter.sv
module self_start_counter
    import ssc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tst_ld,
    input  logic [2:0] tst_code,
    output logic       cnt_c,
    output logic       cnt_b,
    output logic       cnt_a
);
    localparam int unsigned W = ST_W;

    act_e   act;
    code_t  cur;
    code_t  tog;
    state_t st;

    ssc_ctrl u_ctrl (
        .rst (rst),
        .en  (en),
        .ld  (tst_ld),
        .act (act)
    );

    ssc_next u_next (
        .act (act),
        .cur (cur),
        .tog (tog)
    );

    for (genvar i = 0; i < W; i++) begin : g_bit
        ssc_tbit u_bit (
            .clk    (clk),
            .act    (act),
            .t      (tog[i]),
            .ld_val (tst_code[i]),
            .q      (cur[i])
        );
    end

    assign st    = state_t'(cur);
    assign cnt_c = st.c;
    assign cnt_b = st.b;
    assign cnt_a = st.a;

    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            reset_zero_chk: assert (to_code(st) == 3'b000);
        end
    end

    // R2
    cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !tst_ld && !is_unused(cur)) |=> (cur == succ($past(cur))));

    // R3
    unused_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !tst_ld && is_unused(cur)) |=> (cur == 3'b000));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !tst_ld) |=> $stable(cur));

    // R5
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        tst_ld |=> (cur == $past(tst_code)));

    // R7
    no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !tst_ld && is_unused(cur)) |=> !is_unused(cur));
endmodule

// File: tb/sim_self_start_counter.sv
`timescale 1ns/1ps
module sim_self_start_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       tst_ld = 1'b0;
    logic [2:0] tst_code = 3'b000;
    logic       cnt_c, cnt_b, cnt_a;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    self_start_counter u0 (
        .clk(clk), .rst(rst), .en(en), .tst_ld(tst_ld), .tst_code(tst_code),
        .cnt_c(cnt_c), .cnt_b(cnt_b), .cnt_a(cnt_a)
    );

    logic [2:0] ring [5];
    initial begin
        ring[0] = 3'b000; ring[1] = 3'b010; ring[2] = 3'b011;
        ring[3] = 3'b101; ring[4] = 3'b110;
    end

    function automatic logic [2:0] ref_next(input logic [2:0] v);
        logic [2:0] r;
        r = 3'b000;
        for (int k = 0; k < 5; k++)
            if (ring[k] == v) r = ring[(k + 1) % 5];
        return r;
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] got;
        got = {cnt_c, cnt_b, cnt_a};
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic edge_step(input logic r, input logic e, input logic l,
                             input logic [2:0] c);
        @(negedge clk);
        rst = r; en = e; tst_ld = l; tst_code = c;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [2:0] exp;
        edge_step(1, 1, 1, 3'b101);
        check("R1 reset over load/enable", 3'b000);
        edge_step(1, 0, 0, 3'b000);
        check("R1 reset state", 3'b000);

        for (int v = 0; v < 8; v++) begin
            edge_step(0, 0, 1, 3'(v));
            check("R5 load code", 3'(v));
            // R6: bit order checked by comparing each pin with the loaded code
            n_chk++;
            if (cnt_c !== v[2] || cnt_b !== v[1] || cnt_a !== v[0]) begin
                n_err++;
                $display("FAIL R6: got %b%b%b expected %b", cnt_c, cnt_b, cnt_a, 3'(v));
            end
            edge_step(0, 0, 0, 3'b000);
            check("R4 hold", 3'(v));
            edge_step(0, 1, 0, 3'b000);
            exp = ref_next(3'(v));
            if (v == 1 || v == 4 || v == 7) check("R3 unused recovery", 3'b000);
            else                            check("R2 successor", exp);
            edge_step(0, 1, 0, 3'b000);
            check("R7 stays on cycle", ref_next(exp));
        end

        edge_step(0, 1, 1, 3'b111);
        check("R5 load over enable", 3'b111);
        edge_step(0, 1, 0, 3'b000);
        check("R3 from 111", 3'b000);

        edge_step(1, 0, 0, 3'b000);
        check("R1 reset", 3'b000);
        exp = 3'b000;
        for (int s = 0; s < 20; s++) begin
            edge_step(0, 1, 0, 3'b000);
            exp = ref_next(exp);
            check("R2 free run wrap", exp);
            if (s % 7 == 3) begin
                edge_step(0, 0, 0, 3'b000);
                check("R8 no toggle when idle", exp);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule